// File: doc/BRIEF.md
# Page Write Collector with Region Lock and Rewrite Timer

This block sits between the serial-bus protocol controller of a small byte-addressed non-volatile memory and the storage array model. During a write transaction it gathers the data bytes into a one-page staging buffer and marks each slot that was filled. When the bus stop arrives, it sends only the filled slots to the array, one byte per clock. It then holds a busy flag for a fixed number of clocks, which stands in for the internal rewrite time. The protocol controller uses that flag to withhold acknowledges.

The controller pulses `wr_load` with the full word address once the address byte of a write has been received. It pulses `byte_stb` for each data byte that follows, and pulses `bus_start` or `bus_stop` when it sees those bus conditions. A write-protect level can lock either the whole array or its upper half, depending on a parameter. A locked write still runs the full busy period, so a bus master sees the same timing, but no byte reaches the array.

Top module: `page_wbuf`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `busy` and `mem_we` are 0.
- R2: A page holds PAGE_BYTES bytes (default 16). The low log2(PAGE_BYTES) bits of `wr_addr` are the starting offset and the remaining upper bits are the page base. Every committed address is the base followed by the slot offset, so the base never changes within one commit.
- R3: On an accepted stop, each received slot is committed exactly once. Slot i appears on `mem_we`/`mem_addr`/`mem_data` in the (i+1)-th cycle after the stop edge, in ascending offset order. Slots that were not received produce no `mem_we`.
- R4: Each byte goes to the current offset, which then advances and wraps within the page. When more than PAGE_BYTES bytes arrive, the later bytes overwrite earlier ones, and the committed data is the last byte written to each slot.
- R5: A stop that follows a loaded address but no data byte starts no busy period and commits nothing.
- R6: An accepted stop raises `busy` on the next cycle. `busy` stays high for exactly BUSY_CYCLES cycles and then drops.
- R7: While `busy` is high, `wr_load`, `byte_stb`, `bus_start` and `bus_stop` have no effect.
- R8: A `bus_start` before the stop discards all buffered bytes, and no commit follows.
- R9: `wp` is sampled on the stop cycle. If `wp`=1 and the page is locked, no byte is committed, but the busy period still runs. With PROTECT_ALL=0, a page is locked when the most significant bit of its word address is 1. With PROTECT_ALL=1, every page is locked.
- R10: A new `wr_load` clears every buffered slot, so only bytes received after the latest address load are committed.
- R11: Data bytes that arrive with no address loaded since the last start or stop are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_load | input | 1 | Word address of a write has been received |
| wr_addr | input | log2(MEM_BYTES) | Word address, valid with `wr_load` |
| byte_stb | input | 1 | One data byte has been received |
| byte_data | input | 8 | Data byte, valid with `byte_stb` |
| bus_start | input | 1 | Start condition seen on the bus |
| bus_stop | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write-protect level, 1 = protect |
| mem_we | output | 1 | Commit strobe to the array model |
| mem_addr | output | log2(MEM_BYTES) | Array address of the committed byte |
| mem_data | output | 8 | Committed byte |
| busy | output | 1 | Rewrite period in progress |

## Verification
The bench targets the following corner cases.

- Page overflow: a write that runs past the page end must commit the later bytes into the wrapped slots and leave the page base alone. A design that carried the offset into the base would write into the next page.
- Sparse pages: a page must commit only its filled slots. A design that committed every slot would write stale buffer contents.
- Suppressed stops: a stop with no data, a start before the stop, and a second address load are each checked. A design that got these wrong would launch a phantom rewrite or commit discarded bytes.
- Activity during busy: stimulus arrives during the busy window. A design that accepted it would move the page base or start a second rewrite.
- Protection: locked and unlocked halves are both written, and `wp` is pulsed only on the stop cycle. A design that latched protection at the wrong time, or skipped the busy period on a locked page, would show the wrong commit count or `busy` length.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Lock decision: protect level, top address bit of the page, whole-array mode.
  function automatic logic region_locked(input logic wp_in, input logic upper_bit,
                                         input logic whole);
    return wp_in & (whole | upper_bit);
  endfunction
endpackage

// File: rtl/pwb_page_buffer.sv
module pwb_page_buffer #(
  parameter int PAGE_BYTES = 16,
  localparam int OW = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  we,
  input  logic [OW-1:0]         widx,
  input  logic [7:0]            wdata,
  input  logic [OW-1:0]         ridx,
  output logic [7:0]            rdata,
  output logic [PAGE_BYTES-1:0] vld
);
  // data store: one write port, one registered read port
  logic [7:0] store [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
    rdata <= store[ridx];
  end

  // per-slot filled flags
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr) vld[g] <= 1'b0;
      else if (we && widx == OW'(g)) vld[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/pwb_busy_timer.sv
module pwb_busy_timer #(
  parameter int CYCLES = 40,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (go && !busy) begin
      busy   <= 1'b1;
      left_q <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwb_protect.sv
module pwb_protect #(
  parameter int BW = 5,
  parameter bit WHOLE = 1'b0
) (
  input  logic          wp,
  input  logic [BW-1:0] base,
  output logic          locked
);
  import pwb_pkg::*;
  assign locked = region_locked(wp, base[BW-1], WHOLE);
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf #(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 40,
  parameter bit PROTECT_ALL = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_load,
  input  logic [$clog2(MEM_BYTES)-1:0] wr_addr,
  input  logic                         byte_stb,
  input  logic [7:0]                   byte_data,
  input  logic                         bus_start,
  input  logic                         bus_stop,
  input  logic                         wp,
  output logic                         mem_we,
  output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
  output logic [7:0]                   mem_data,
  output logic                         busy
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int BW = AW - OW;

  if (BUSY_CYCLES <= PAGE_BYTES) begin : g_bad_timing
    $error("BUSY_CYCLES must exceed PAGE_BYTES so the drain completes");
  end

  logic                  armed_q;
  logic [BW-1:0]         base_q;
  logic [OW-1:0]         off_q;
  logic [PAGE_BYTES-1:0] vld, pend_q;
  logic                  prot_q, prot_now;
  logic                  drain_q;
  logic [OW-1:0]         scan_q;
  logic                  we_q;
  logic [AW-1:0]         addr_q;

  // event decode, in priority order: start, load, stop, byte
  logic idle, take_start, take_load, take_stop, take_byte, go, clr;
  always_comb begin
    idle       = !busy;
    take_start = idle && bus_start;
    take_load  = idle && !bus_start && wr_load;
    take_stop  = idle && !bus_start && !wr_load && bus_stop;
    take_byte  = idle && !bus_start && !wr_load && !bus_stop && byte_stb && armed_q;
    go         = take_stop && armed_q && (|vld);
    clr        = take_start || take_load || take_stop;
  end

  pwb_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst(rst), .clr(clr), .we(take_byte), .widx(off_q),
    .wdata(byte_data), .ridx(scan_q), .rdata(mem_data), .vld(vld)
  );

  pwb_protect #(.BW(BW), .WHOLE(PROTECT_ALL)) u_prot (
    .wp(wp), .base(base_q), .locked(prot_now)
  );

  pwb_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .go(go), .busy(busy)
  );

  // transaction tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      base_q  <= '0;
      off_q   <= '0;
    end else if (take_start || take_stop) begin
      armed_q <= 1'b0;
    end else if (take_load) begin
      armed_q <= 1'b1;
      base_q  <= wr_addr[AW-1:OW];
      off_q   <= wr_addr[OW-1:0];
    end else if (take_byte) begin
      off_q   <= off_q + 1'b1;
    end
  end

  // drain of received slots toward the array
  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q <= 1'b0;
      scan_q  <= '0;
      pend_q  <= '0;
      prot_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (go) begin
        drain_q <= 1'b1;
        scan_q  <= '0;
        pend_q  <= vld;
        prot_q  <= prot_now;
      end else if (drain_q) begin
        we_q   <= pend_q[scan_q] & ~prot_q;
        addr_q <= {base_q, scan_q};
        scan_q <= scan_q + 1'b1;
        if (scan_q == OW'(PAGE_BYTES - 1)) drain_q <= 1'b0;
      end
    end
  end

  assign mem_we   = we_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/page_wbuf_chk.sv
module page_wbuf_chk #(
  parameter int AW = 9,
  parameter int OW = 4,
  parameter int BC = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_stop,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          prot_q
);
  int run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else run_q <= 0;
  end

  // R3
  commit_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R6
  busy_follows_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_stop));

  // R6
  busy_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == BC);

  // R9
  no_locked_commit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !prot_q);

  // R2
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr[AW-1:OW] == $past(mem_addr[AW-1:OW]));
endmodule

bind page_wbuf page_wbuf_chk #(.AW(AW), .OW(OW), .BC(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .bus_stop(bus_stop), .busy(busy),
  .mem_we(mem_we), .mem_addr(mem_addr), .prot_q(prot_q)
);

// File: tb/page_wbuf_test.sv
module page_wbuf_test;
  localparam int MEM  = 512;
  localparam int PAGE = 16;
  localparam int BC   = 40;
  localparam int AW   = 9;
  localparam int OW   = 4;
  localparam int BW   = AW - OW;
  localparam bit PALL = 1'b0;

  logic clk = 0, rst = 1;
  logic wr_load = 0, byte_stb = 0, bus_start = 0, bus_stop = 0, wp = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] byte_data = '0;
  logic mem_we, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;

  page_wbuf #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .BUSY_CYCLES(BC), .PROTECT_ALL(PALL)) uut (
    .clk(clk), .rst(rst), .wr_load(wr_load), .wr_addr(wr_addr), .byte_stb(byte_stb),
    .byte_data(byte_data), .bus_start(bus_start), .bus_stop(bus_stop), .wp(wp),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy)
  );

  always #2 clk = ~clk;

  int errs = 0, checks = 0, commits = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  int  mbuf[PAGE];
  bit  mvld[PAGE];
  bit  marmed = 0;
  int  mbase = 0, moff = 0;
  int  edge_n = 0, s_edge = -1000;
  int  sbuf[PAGE];
  bit  svld[PAGE];
  bit  sprot = 0;
  int  sbase = 0;
  bit  was_busy, anyv;

  always @(posedge clk) begin
    if (rst) begin
      marmed = 0; s_edge = -1000; edge_n = 0;
      for (int k = 0; k < PAGE; k++) mvld[k] = 0;
    end else begin
      was_busy = (edge_n >= s_edge) && (edge_n <= s_edge + BC - 1);
      edge_n++;
      if (!was_busy) begin
        if (bus_start) begin
          marmed = 0;
          for (int k = 0; k < PAGE; k++) mvld[k] = 0;
        end else if (wr_load) begin
          marmed = 1;
          mbase = int'(wr_addr) / PAGE;
          moff  = int'(wr_addr) % PAGE;
          for (int k = 0; k < PAGE; k++) mvld[k] = 0;
        end else if (bus_stop) begin
          anyv = 0;
          for (int k = 0; k < PAGE; k++) anyv |= mvld[k];
          if (marmed && anyv) begin
            s_edge = edge_n;
            for (int k = 0; k < PAGE; k++) begin sbuf[k] = mbuf[k]; svld[k] = mvld[k]; end
            sprot = wp && (PALL || mbase >= (1 << (BW - 1)));
            sbase = mbase;
          end
          marmed = 0;
          for (int k = 0; k < PAGE; k++) mvld[k] = 0;
        end else if (byte_stb && marmed) begin
          mbuf[moff] = int'(byte_data);
          mvld[moff] = 1;
          moff = (moff + 1) % PAGE;
        end
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin : cmp_blk
    int  i;
    bit  eb, ew;
    if (!rst) begin
      eb = (edge_n >= s_edge) && (edge_n <= s_edge + BC - 1);
      chk(busy == eb, "R6 busy window", int'(busy), int'(eb));
      i  = edge_n - s_edge - 1;
      ew = 0;
      if (i >= 0 && i < PAGE) ew = svld[i] && !sprot;
      chk(mem_we == ew, "R3 commit strobe", int'(mem_we), int'(ew));
      if (ew && mem_we) begin
        chk(int'(mem_addr) == sbase * PAGE + i, "R2 commit address", int'(mem_addr), sbase * PAGE + i);
        chk(int'(mem_data) == sbuf[i], "R4 commit data", int'(mem_data), sbuf[i]);
      end
      if (mem_we) commits++;
    end
  end

  // drivers: entered at a falling edge, leave at the next one
  task automatic do_load(input int a);
    wr_load = 1; wr_addr = AW'(a); @(negedge clk); wr_load = 0;
  endtask
  task automatic do_byte(input int d);
    byte_stb = 1; byte_data = 8'(d); @(negedge clk); byte_stb = 0;
  endtask
  task automatic do_stop();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic do_start();
    bus_start = 1; @(negedge clk); bus_start = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : main
    int c0;
    @(negedge clk);
    idle(3);
    // R1 reset state
    chk(busy == 0, "R1 busy in reset", int'(busy), 0);
    chk(mem_we == 0, "R1 commit in reset", int'(mem_we), 0);
    rst = 0;
    chk(busy == 0 && mem_we == 0, "R1 after reset", int'(busy), 0);
    idle(2);

    // R11 bytes with no address loaded
    c0 = commits;
    do_byte(8'h11); do_byte(8'h22); do_stop();
    chk(busy == 0, "R11 stray bytes start no rewrite", int'(busy), 0);
    idle(4);
    chk(commits == c0, "R11 stray bytes commit nothing", commits - c0, 0);

    // R3 single byte
    c0 = commits;
    do_load(9'h023); do_byte(8'hA5); do_stop();
    chk(busy == 1, "R6 busy after stop", int'(busy), 1);
    idle(BC + 4);
    chk(commits - c0 == 1, "R3 single byte count", commits - c0, 1);

    // R3 partial page
    c0 = commits;
    do_load(9'h040);
    for (int k = 0; k < 5; k++) do_byte(8'h30 + k);
    do_stop(); idle(BC + 4);
    chk(commits - c0 == 5, "R3 partial page count", commits - c0, 5);

    // R4 wrap past page end
    c0 = commits;
    do_load(9'h05C);
    for (int k = 0; k < 20; k++) do_byte(k * 7 + 3);
    do_stop(); idle(BC + 4);
    chk(commits - c0 == 16, "R4 wrapped page count", commits - c0, 16);

    // R5 stop with no data
    c0 = commits;
    do_load(9'h010); do_stop();
    chk(busy == 0, "R5 empty stop no busy", int'(busy), 0);
    idle(4);
    chk(commits == c0, "R5 empty stop no commit", commits - c0, 0);

    // R8 start discards
    c0 = commits;
    do_load(9'h030); do_byte(1); do_byte(2); do_byte(3); do_start(); do_stop();
    chk(busy == 0, "R8 discarded page no busy", int'(busy), 0);
    idle(4);
    chk(commits == c0, "R8 discarded page no commit", commits - c0, 0);

    // R10 reload clears slots
    c0 = commits;
    do_load(9'h080); do_byte(8'hC1); do_byte(8'hC2);
    do_load(9'h0A0); do_byte(8'hD1); do_stop(); idle(BC + 4);
    chk(commits - c0 == 1, "R10 only post-reload bytes", commits - c0, 1);

    // R7 activity during busy is ignored
    c0 = commits;
    do_load(9'h060); do_byte(8'h61); do_byte(8'h62); do_stop();
    idle(3);
    do_load(9'h1F0); do_byte(8'hEE); do_byte(8'hEF); do_byte(8'hF0); do_stop(); do_start();
    idle(BC);
    chk(busy == 0, "R7 busy ended on time", int'(busy), 0);
    do_byte(8'h99); do_stop();
    chk(busy == 0, "R7 load during busy not taken", int'(busy), 0);
    idle(4);
    chk(commits - c0 == 2, "R7 commit count", commits - c0, 2);

    // R9 locked upper half still runs busy
    c0 = commits;
    do_load(9'h150); for (int k = 0; k < 4; k++) do_byte(8'h50 + k);
    wp = 1; do_stop(); wp = 0;
    chk(busy == 1, "R9 locked page still busy", int'(busy), 1);
    idle(BC + 4);
    chk(commits == c0, "R9 locked page no commit", commits - c0, 0);

    // R9 lower half with protect high
    c0 = commits;
    wp = 1;
    do_load(9'h020); do_byte(8'h71); do_byte(8'h72); do_stop();
    wp = 0; idle(BC + 4);
    chk(commits - c0 == 2, "R9 lower half writable", commits - c0, 2);

    // R9 upper half with protect low
    c0 = commits;
    do_load(9'h1E8); for (int k = 0; k < 3; k++) do_byte(8'h80 + k);
    do_stop(); idle(BC + 4);
    chk(commits - c0 == 3, "R9 upper half unprotected", commits - c0, 3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule